// File: doc/BRIEF.md
# CORDIC Sine/Cosine Oscillator

This block is a numerically controlled oscillator that emits one cosine and one sine sample per accepted cycle. A wide phase accumulator moves forward by a programmable step each time a sample is taken. A field of its upper bits is read as an angle in binary fractions of one turn. Any bits above that field count whole turns, and the rotator never looks at them. The top two bits of the angle select a quadrant. The start vector is turned into that quadrant by swapping and negating its components. A pipeline of CORDIC micro-rotations then turns it through the remaining angle, which lies within plus or minus one eighth of a turn.

The rotator has a fixed gain of about 1.64676. That gain is cancelled before rotation: the requested peak amplitude is multiplied by the constant reciprocal, and the product becomes the starting X component. The starting Y component is zero. The datapath carries guard bits below the output LSB and one bit of headroom. Each result is truncated and then clamped to the output width.

Samples leave through a valid/ready port. While `out_valid` is high and `out_ready` is low, the whole pipeline and the accumulator hold still, and `enable` has no effect. A sample is taken in any cycle where `enable` is high and the output is not stalled. Whenever the output is not stalled, one sample can be taken and one sample can leave in the same clock.

Top module: `cordic_nco`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and the accumulator is cleared. The first sample taken after reset therefore has phase 0, giving a cosine of +amplitude and a sine of 0.
- R2: The phase of the n-th sample after reset (n counted from 0) is bits [23:6] of (n × `phase_inc`) mod 2^26, with one turn = 2^18 phase units. Bits [25:24] count whole turns and do not change the outputs, so steps of 1.25 turns and 0.25 turns give the same samples.
- R3: For every sample, `out_cos` and `out_sin` (two's complement, 12 bits) are within 3 LSB of amplitude × cos(2π·p/2^18) and amplitude × sin(2π·p/2^18), where p is that sample's phase.
- R4: At the quadrant points p = 0, 2^16, 2^17 and 3·2^16, the output pair (cos, sin) is (A,0), (0,A), (−A,0) and (0,−A) within 3 LSB. This holds up to full scale, A = 2047.
- R5: In a cycle where `enable` is low, no sample is taken and the accumulator does not move. Every sample that is taken leaves the port exactly once, in order.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_cos` and `out_sin` hold their values, and the accumulator does not move.
- R7: With `out_ready` held high, a sample taken at a rising edge appears with `out_valid` high after 16 rising edges (ITER + 2 for ITER = 14), counting the edge that took the sample.
- R8: The final residual angle after the last micro-rotation stays within the last arctangent step plus one phase unit per iteration, and the output vector never exceeds the full-scale circle by more than 4 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Take a sample this cycle when not stalled |
| phase_inc | input | 26 | Phase step per sample, unsigned, wraps mod 2^26 |
| amplitude | input | 11 | Peak output magnitude, unsigned |
| out_ready | input | 1 | Downstream accepts a sample |
| out_valid | output | 1 | Output sample present |
| out_cos | output | 12 | Cosine sample, two's complement |
| out_sin | output | 12 | Sine sample, two's complement |

## Verification
The hardest case to reach from the ports is a stall that lands while samples are scattered through the pipeline with bubbles between them. A stall at that point must freeze the accumulator without dropping a sample or taking one twice. The stimulus draws `enable` and `out_ready` at random each cycle, at several densities. The bench then checks the n-th sample that leaves against the phase n × step, so one slipped or duplicated sample shifts every later phase and fails the checks. Directed runs with quarter-turn steps, and with steps that include whole turns or wrap backwards, reach the exact quadrant points and the overflow of the turn bits.

// File: rtl/cordic_nco_pkg.sv
package cordic_nco_pkg;

  localparam real TWO_PI   = 6.283185307179586;
  localparam real INV_GAIN = 0.6072529350088813;

  // arctangent of 2^-i expressed in units of 2^-ph_w of a revolution
  function automatic int atan_rev(input int i, input int ph_w);
    real a;
    a = $atan(2.0 ** (-i)) / TWO_PI * (2.0 ** ph_w);
    return $rtoi(a + 0.5);
  endfunction

  // gain reciprocal quantised to kf_w fractional bits
  function automatic int inv_gain_q(input int kf_w);
    return $rtoi(INV_GAIN * (2.0 ** kf_w) + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= acc_q + step;
  end
endmodule

// File: rtl/nco_prerot.sv
module nco_prerot #(
  parameter int PH_W    = 18,
  parameter int OUT_W   = 12,
  parameter int GUARD_W = 4,
  parameter int DP_W    = 17,
  parameter int KF_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   advance,
  input  logic                   take,
  input  logic [PH_W-1:0]        phase,
  input  logic [OUT_W-2:0]       amplitude,
  output logic                   v_o,
  output logic signed [DP_W-1:0] x_o,
  output logic signed [DP_W-1:0] y_o,
  output logic signed [PH_W-1:0] z_o
);
  localparam int AMP_W = OUT_W - 1;
  localparam int PRD_W = AMP_W + KF_W;
  localparam int SC_W  = AMP_W + GUARD_W;
  localparam logic [KF_W-1:0] KINV   = KF_W'(cordic_nco_pkg::inv_gain_q(KF_W));
  localparam logic [PH_W-1:0] EIGHTH = PH_W'(1) << (PH_W - 3);

  logic [PRD_W-1:0]       prod;
  logic [SC_W-1:0]        scaled;
  logic signed [DP_W-1:0] x0;
  logic [PH_W-1:0]        biased;
  logic [1:0]             quad;
  logic [PH_W-1:0]        resid;
  logic signed [DP_W-1:0] xn, yn;

  // gain pre-scale: amplitude * (1/K), kept with GUARD_W fraction bits
  assign prod   = {{KF_W{1'b0}}, amplitude} * {{AMP_W{1'b0}}, KINV};
  assign scaled = SC_W'(prod >> (KF_W - GUARD_W));
  assign x0     = signed'({{(DP_W - SC_W){1'b0}}, scaled});

  // fold the angle to the nearest quarter turn
  assign biased = phase + EIGHTH;
  assign quad   = biased[PH_W-1 -: 2];
  assign resid  = phase - {quad, {(PH_W-2){1'b0}}};

  always_comb begin
    unique case (quad)
      2'd0:    begin xn = x0;  yn = '0;  end
      2'd1:    begin xn = '0;  yn = x0;  end
      2'd2:    begin xn = -x0; yn = '0;  end
      default: begin xn = '0;  yn = -x0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0; x_o <= '0; y_o <= '0; z_o <= '0;
    end else if (advance) begin
      v_o <= take;
      x_o <= xn;
      y_o <= yn;
      z_o <= signed'(resid);
    end
  end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int DP_W  = 17,
  parameter int ZW    = 18,
  parameter int SHIFT = 0,
  parameter int ATAN  = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   advance,
  input  logic                   v_i,
  input  logic signed [DP_W-1:0] x_i,
  input  logic signed [DP_W-1:0] y_i,
  input  logic signed [ZW-1:0]   z_i,
  output logic                   v_o,
  output logic signed [DP_W-1:0] x_o,
  output logic signed [DP_W-1:0] y_o,
  output logic signed [ZW-1:0]   z_o
);
  localparam logic signed [ZW-1:0] STEP = ZW'(ATAN);

  logic signed [DP_W-1:0] xs, ys;
  logic                   ccw;

  assign xs  = x_i >>> SHIFT;
  assign ys  = y_i >>> SHIFT;
  assign ccw = ~z_i[ZW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0; x_o <= '0; y_o <= '0; z_o <= '0;
    end else if (advance) begin
      v_o <= v_i;
      if (ccw) begin
        x_o <= x_i - ys;
        y_o <= y_i + xs;
        z_o <= z_i - STEP;
      end else begin
        x_o <= x_i + ys;
        y_o <= y_i - xs;
        z_o <= z_i + STEP;
      end
    end
  end
endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage #(
  parameter int DP_W    = 17,
  parameter int OUT_W   = 12,
  parameter int GUARD_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    advance,
  input  logic                    v_i,
  input  logic signed [DP_W-1:0]  x_i,
  input  logic signed [DP_W-1:0]  y_i,
  output logic                    v_o,
  output logic signed [OUT_W-1:0] c_o,
  output logic signed [OUT_W-1:0] s_o
);
  localparam logic signed [DP_W-1:0] HI = DP_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [DP_W-1:0] LO = -DP_W'(1 << (OUT_W - 1));

  logic signed [DP_W-1:0]  xt, yt;
  logic signed [OUT_W-1:0] xc, yc;

  assign xt = x_i >>> GUARD_W;
  assign yt = y_i >>> GUARD_W;

  always_comb begin
    if (xt > HI)      xc = OUT_W'(HI);
    else if (xt < LO) xc = OUT_W'(LO);
    else              xc = OUT_W'(xt);
    if (yt > HI)      yc = OUT_W'(HI);
    else if (yt < LO) yc = OUT_W'(LO);
    else              yc = OUT_W'(yt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0; c_o <= '0; s_o <= '0;
    end else if (advance) begin
      v_o <= v_i;
      c_o <= xc;
      s_o <= yc;
    end
  end
endmodule

// File: rtl/cordic_nco.sv
module cordic_nco #(
  parameter int OUT_W   = 12,
  parameter int GUARD_W = 4,
  parameter int ITER    = 14,
  parameter int PH_W    = 18,
  parameter int FRAC_W  = 6,
  parameter int REV_W   = 2,
  parameter int KF_W    = 16,
  localparam int ACC_W  = REV_W + PH_W + FRAC_W,
  localparam int DP_W   = OUT_W + GUARD_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [ACC_W-1:0]        phase_inc,
  input  logic [OUT_W-2:0]        amplitude,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_cos,
  output logic signed [OUT_W-1:0] out_sin
);
  logic             advance;
  logic             take;
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  phase;

  logic                   sv [0:ITER];
  logic signed [DP_W-1:0] sx [0:ITER];
  logic signed [DP_W-1:0] sy [0:ITER];
  logic signed [PH_W-1:0] sz [0:ITER];

  // whole pipeline freezes while a sample waits at the port
  assign advance = ~out_valid | out_ready;
  assign take    = enable & advance;
  assign phase   = acc_q[FRAC_W +: PH_W];

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .step(phase_inc), .acc_q(acc_q)
  );

  nco_prerot #(
    .PH_W(PH_W), .OUT_W(OUT_W), .GUARD_W(GUARD_W), .DP_W(DP_W), .KF_W(KF_W)
  ) u_prerot (
    .clk(clk), .rst_n(rst_n), .advance(advance), .take(take),
    .phase(phase), .amplitude(amplitude),
    .v_o(sv[0]), .x_o(sx[0]), .y_o(sy[0]), .z_o(sz[0])
  );

  for (genvar i = 0; i < ITER; i++) begin : g_rot
    cordic_stage #(
      .DP_W(DP_W), .ZW(PH_W), .SHIFT(i),
      .ATAN(cordic_nco_pkg::atan_rev(i, PH_W))
    ) u_stage (
      .clk(clk), .rst_n(rst_n), .advance(advance),
      .v_i(sv[i]),   .x_i(sx[i]),   .y_i(sy[i]),   .z_i(sz[i]),
      .v_o(sv[i+1]), .x_o(sx[i+1]), .y_o(sy[i+1]), .z_o(sz[i+1])
    );
  end

  nco_out_stage #(.DP_W(DP_W), .OUT_W(OUT_W), .GUARD_W(GUARD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .v_i(sv[ITER]), .x_i(sx[ITER]), .y_i(sy[ITER]),
    .v_o(out_valid), .c_o(out_cos), .s_o(out_sin)
  );
endmodule

// File: rtl/cordic_nco_chk.sv
module cordic_nco_chk #(
  parameter int OUT_W = 12,
  parameter int ITER  = 14,
  parameter int PH_W  = 18,
  parameter int ACC_W = 26
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic                    out_ready,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_cos,
  input logic signed [OUT_W-1:0] out_sin,
  input logic [ACC_W-1:0]        acc_q,
  input logic                    last_v,
  input logic signed [PH_W-1:0]  last_z
);
  localparam int ZLIM  = cordic_nco_pkg::atan_rev(ITER - 1, PH_W) + ITER;
  localparam int FS    = (1 << (OUT_W - 1)) + 4;
  localparam int MAXSQ = FS * FS;

  // R1
  rst_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cos) && $stable(out_sin)));

  // R6
  stall_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(acc_q));

  // R5
  idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(acc_q));

  // R8
  resid_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_v |-> (int'(last_z) <= ZLIM && int'(last_z) >= -ZLIM));

  // R8
  circle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_cos) * int'(out_cos) + int'(out_sin) * int'(out_sin) <= MAXSQ));
endmodule

bind cordic_nco cordic_nco_chk #(
  .OUT_W(OUT_W), .ITER(ITER), .PH_W(PH_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .out_ready(out_ready),
  .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin),
  .acc_q(acc_q), .last_v(sv[ITER]), .last_z(sz[ITER])
);

// File: tb/cordic_nco_bench.sv
`timescale 1ns/1ps
module cordic_nco_bench;
  localparam int OUT_W  = 12;
  localparam int ITER   = 14;
  localparam int PH_W   = 18;
  localparam int FRAC_W = 6;
  localparam int REV_W  = 2;
  localparam int ACC_W  = REV_W + PH_W + FRAC_W;
  localparam int TOL    = 3;
  localparam longint unsigned ACC_MASK = (64'd1 << ACC_W) - 1;
  localparam longint unsigned QUARTER  = 64'd1 << (FRAC_W + PH_W - 2);
  localparam longint unsigned TURN     = 64'd1 << (FRAC_W + PH_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [ACC_W-1:0] phase_inc = '0;
  logic [OUT_W-2:0] amplitude = '0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_cos, out_sin;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cordic_nco u_cordic_nco (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phase_inc(phase_inc),
    .amplitude(amplitude), .out_ready(out_ready), .out_valid(out_valid),
    .out_cos(out_cos), .out_sin(out_sin)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ideal(input longint unsigned inc, input int k,
                               input int amp, input bit want_sin);
    longint unsigned acc;
    longint unsigned p;
    real ang, v;
    acc = (inc * longint'(k)) & ACC_MASK;
    p   = (acc >> FRAC_W) & ((64'd1 << PH_W) - 1);
    ang = 6.283185307179586 * real'(p) / (2.0 ** PH_W);
    v   = want_sin ? real'(amp) * $sin(ang) : real'(amp) * $cos(ang);
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
  endtask

  // stream run: random enable/ready densities, every output compared
  task automatic run_stream(input longint unsigned inc, input int amp, input int ncyc,
                            input int en_pct, input int rdy_pct, input string req);
    int k = 0;
    int taken = 0;
    bit hold_pend = 1'b0;
    int hc = 0, hs = 0;
    do_reset();
    phase_inc = ACC_W'(inc);
    amplitude = (OUT_W-1)'(amp);
    for (int c = 0; c < ncyc + ITER + 8; c++) begin
      @(negedge clk);
      if (hold_pend)
        check(out_valid && int'(out_cos) == hc && int'(out_sin) == hs, "R6",
              "held cos under stall", int'(out_cos), hc);
      if (c < ncyc) begin
        enable    = ($urandom_range(99) < en_pct);
        out_ready = ($urandom_range(99) < rdy_pct);
      end else begin
        enable = 1'b0; out_ready = 1'b1;
      end
      if (enable && (!out_valid || out_ready)) taken++;
      if (out_valid && out_ready) begin
        int ec, es;
        ec = ideal(inc, k, amp, 1'b0);
        es = ideal(inc, k, amp, 1'b1);
        check((int'(out_cos) - ec <= TOL) && (ec - int'(out_cos) <= TOL),
              (k == 0) ? "R1" : req, "cos", int'(out_cos), ec);
        check((int'(out_sin) - es <= TOL) && (es - int'(out_sin) <= TOL),
              (k == 0) ? "R1" : req, "sin", int'(out_sin), es);
        k++;
      end
      hold_pend = out_valid && !out_ready;
      hc = int'(out_cos); hs = int'(out_sin);
    end
    check(k == taken, "R5", "samples out vs taken", k, taken);
  endtask

  task automatic latency_check();
    int n = 0;
    do_reset();
    phase_inc = ACC_W'(QUARTER);
    amplitude = 11'd1000;
    out_ready = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    n = 1;
    while (!out_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n == ITER + 2, "R7", "edges to out_valid", n, ITER + 2);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "single sample only", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    latency_check();
    // R4 quadrant points at full scale
    run_stream(QUARTER, 2047, 40, 100, 100, "R4");
    // R2 whole turns above the phase field are ignored
    run_stream(TURN + QUARTER, 1500, 40, 100, 100, "R2");
    // R2 backwards wrap of the accumulator
    run_stream((TURN * 4 - 64'd777_777) & ACC_MASK, 1800, 80, 100, 100, "R2");
    // R3 random steps and amplitudes
    for (int r = 0; r < 5; r++) begin
      longint unsigned inc;
      int amp;
      inc = {$urandom, $urandom} & ACC_MASK;
      amp = 256 + int'($urandom_range(1791));
      run_stream(inc, amp, 200, 100, 100, "R3");
    end
    // R5 sparse enable
    run_stream(64'd123_457, 1900, 300, 30, 100, "R5");
    // R6 heavy back-pressure with bubbles
    run_stream(64'd2_345_679, 1234, 400, 70, 35, "R6");
    run_stream(QUARTER / 3, 2047, 400, 50, 50, "R6");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule